// File: doc/BRIEF.md
# Receive Frame Error Classifier

This block sits beside the receive path of an Ethernet MAC and watches each incoming frame one byte beat at a time. A beat is marked as the first or last of a frame. On the last beat, the beat also carries the number of leftover bits that followed the final whole byte and a CRC-good verdict from an upstream checker. The block counts bytes and gives a downstream buffer a per-beat write enable. That enable is cut off once the maximum legal length has been written, so an oversize frame is stored truncated.

One cycle after the last beat, the block publishes five status flags: CRC error, short frame, oversize, dribble and alignment. It also publishes a keep/discard verdict, using one accept bit per error class, and a one-cycle interrupt pulse, using one enable bit per flag. The flags stay unchanged until the next frame begins. A short frame is only recognised at the end, so the write enable cannot withhold it. The downstream buffer drops a stored frame whenever the verdict says discard.

Length tracking is done by a three-state machine:
- **IDLE**: no frame open. Beats without a start marker are ignored.
- **RECV**: bytes are being written.
- **TRUNC**: the maximum length has been written and further bytes are swallowed.

Its transitions are:
- *open*: a start beat in IDLE goes to RECV.
- *fill*: the beat that writes byte MAX_LEN goes from RECV to TRUNC.
- *close*: an end beat returns from any state to IDLE.
- *restart*: a start beat in RECV or TRUNC begins a new frame at length 1 in RECV.

Top module: `rx_frame_classifier`

## Requirements
- R1: After reset the status flags, `done`, `keep`, `irq` and `wr_en` are all 0.
- R2: `wr_en` is high, in the same cycle, for each valid beat of an open frame whose byte position is at most MAX_LEN (1518). It is low for later bytes and for beats outside a frame.
- R3: Status bit 0 (CRC error) is set from the inverse of `in_crc_good` on the end beat and appears the cycle after that beat.
- R4: Status bit 1 (short frame) is set when the frame length, counting the start and end beats, is below MIN_LEN (64).
- R5: Status bit 2 (oversize) is set when the frame length exceeds MAX_LEN.
- R6: Status bit 3 (dribble) is set when `in_tail_bits` on the end beat is nonzero. The leftover bits are never written.
- R7: Status bit 4 (alignment) is set exactly when the dribble bit and the CRC error bit are both set for the frame.
- R8: `keep` is 1 when the frame has no CRC error, short-frame or oversize condition, or when every such condition present has its accept bit (`acc_crc`, `acc_short`, `acc_long`) set. Dribble alone never causes a discard.
- R9: `done` pulses high for exactly one cycle, the cycle after each end beat. `keep` is only high together with `done`.
- R10: `irq` is a one-cycle pulse alongside `done`, equal to the OR over bits i of (status bit i AND `irq_en[i]`).
- R11: The status flags hold their value until the next start beat and read 0 in the cycle after a start beat that is not also an end beat.
- R12: A start beat inside an open frame abandons that frame and begins a new one at length 1. A beat carrying both markers is a one-byte frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A byte beat is present |
| in_sof | input | 1 | Beat is the first of a frame |
| in_eof | input | 1 | Beat is the last of a frame |
| in_tail_bits | input | 3 | Leftover bit count after last byte, sampled on end beat |
| in_crc_good | input | 1 | Upstream CRC check passed, sampled on end beat |
| acc_crc | input | 1 | Keep frames with a CRC error |
| acc_short | input | 1 | Keep frames shorter than MIN_LEN |
| acc_long | input | 1 | Keep oversize frames (truncated) |
| irq_en | input | 5 | Interrupt enable per status bit |
| wr_en | output | 1 | Write enable to the frame buffer for this beat |
| done | output | 1 | End-of-frame verdict strobe |
| keep | output | 1 | Frame is to be retained (valid with done) |
| irq | output | 1 | Interrupt pulse |
| stat | output | 5 | Status flags {align, dribble, oversize, short, crc} |

## Verification
The bench probes the length boundaries: 63 versus 64 bytes, and 1518 versus 1519 bytes. An off-by-one counter would flag the wrong frame or write one byte too many or too few. It also sends a 1600-byte frame, where a counter that wraps or stops tracking would re-enable writes or lose the oversize flag. Other stimuli are a one-byte frame with both markers, a start marker inside an open frame, idle gaps within a frame, and stray beats outside any frame. A design that mishandles them would carry a stale count into the next frame or write unowned bytes. Accept and interrupt-enable settings are swept over frames with several errors at once, which exposes an OR-instead-of-AND verdict, alignment flagged without dribble, or an interrupt that lasts longer than one cycle.

// File: rtl/rxc_pkg.sv
package rxc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RECV  = 2'd1,
        ST_TRUNC = 2'd2
    } rxc_state_e;

    localparam int FLAG_W = 5;
    localparam int TAIL_W = 3;
    localparam int FL_CRC   = 0;
    localparam int FL_SHORT = 1;
    localparam int FL_LONG  = 2;
    localparam int FL_DRIB  = 3;
    localparam int FL_ALIGN = 4;
endpackage

// File: rtl/rxc_len_tracker.sv
module rxc_len_tracker
    import rxc_pkg::*;
#(
    parameter int MIN_LEN = 64,
    parameter int MAX_LEN = 1518
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic in_sof,
    input  logic in_eof,
    output logic wr_en,
    output logic end_beat,
    output logic start_beat,
    output logic is_short,
    output logic is_long
);
    localparam int CNT_W = $clog2(MAX_LEN + 1);
    localparam logic [CNT_W:0] MAX_L = (CNT_W + 1)'(MAX_LEN);
    localparam logic [CNT_W:0] MIN_L = (CNT_W + 1)'(MIN_LEN);

    rxc_state_e state, nxt;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W:0]   len_now;
    logic             beat;

    assign beat       = in_valid && (in_sof || state != ST_IDLE);
    assign start_beat = in_valid && in_sof;
    assign end_beat   = beat && in_eof;
    assign len_now    = in_sof ? (CNT_W + 1)'(1) : ({1'b0, cnt} + 1'b1);

    // Output process
    always_comb begin
        wr_en    = 1'b0;
        is_long  = 1'b0;
        unique case (state)
            ST_IDLE:  wr_en = start_beat;
            ST_RECV:  wr_en = in_valid;
            ST_TRUNC: begin
                wr_en   = start_beat;
                is_long = !in_sof;
            end
            default:  wr_en = 1'b0;
        endcase
        is_short = !is_long && (len_now < MIN_L);
    end

    // Next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (start_beat && !in_eof)
                    nxt = (len_now == MAX_L) ? ST_TRUNC : ST_RECV;
            end
            ST_RECV: begin
                if (beat) begin
                    if (in_eof)                 nxt = ST_IDLE;
                    else if (len_now == MAX_L)  nxt = ST_TRUNC;
                    else                        nxt = ST_RECV;
                end
            end
            ST_TRUNC: begin
                if (beat) begin
                    if (in_eof)      nxt = ST_IDLE;
                    else if (in_sof) nxt = (len_now == MAX_L) ? ST_TRUNC : ST_RECV;
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Byte counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (beat) begin
            if (in_eof)
                cnt <= '0;
            else if (in_sof || state == ST_RECV)
                cnt <= len_now[CNT_W-1:0];
        end
    end

    assert_cnt_bounded_R2: assert property (@(posedge clk) disable iff (!rst_n)
        {1'b0, cnt} <= MAX_L);

    assert_enter_trunc_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RECV && in_valid && !in_sof && !in_eof && {1'b0, cnt} == MAX_L - 1'b1)
        |=> (state == ST_TRUNC));

    assert_restart_len_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (start_beat && !in_eof) |=> (cnt == CNT_W'(1)));

    assert_close_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        end_beat |=> (state == ST_IDLE));
endmodule

// File: rtl/rxc_verdict.sv
module rxc_verdict
    import rxc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              end_beat,
    input  logic              start_beat,
    input  logic              is_short,
    input  logic              is_long,
    input  logic              in_crc_good,
    input  logic [TAIL_W-1:0] in_tail_bits,
    input  logic              acc_crc,
    input  logic              acc_short,
    input  logic              acc_long,
    input  logic [FLAG_W-1:0] irq_en,
    output logic [FLAG_W-1:0] stat,
    output logic              done,
    output logic              keep,
    output logic              irq
);
    logic [FLAG_W-1:0] flags;
    logic              keep_c;

    always_comb begin
        flags           = '0;
        flags[FL_CRC]   = !in_crc_good;
        flags[FL_SHORT] = is_short;
        flags[FL_LONG]  = is_long;
        flags[FL_DRIB]  = (in_tail_bits != '0);
        flags[FL_ALIGN] = flags[FL_DRIB] && flags[FL_CRC];
        keep_c = (!flags[FL_CRC]   || acc_crc)
              && (!flags[FL_SHORT] || acc_short)
              && (!flags[FL_LONG]  || acc_long);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat <= '0;
            done <= 1'b0;
            keep <= 1'b0;
            irq  <= 1'b0;
        end else begin
            done <= end_beat;
            keep <= end_beat && keep_c;
            irq  <= end_beat && |(flags & irq_en);
            if (end_beat)        stat <= flags;
            else if (start_beat) stat <= '0;
        end
    end

    assert_align_needs_both_R7: assert property (@(posedge clk) disable iff (!rst_n)
        stat[FL_ALIGN] |-> (stat[FL_DRIB] && stat[FL_CRC]));

    assert_done_follows_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
        end_beat |=> done);

    assert_keep_with_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        keep |-> done);

    assert_irq_with_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> done);

    assert_stat_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!end_beat && !start_beat) |=> $stable(stat));
endmodule

// File: rtl/rx_frame_classifier.sv
module rx_frame_classifier
    import rxc_pkg::*;
#(
    parameter int MIN_LEN = 64,
    parameter int MAX_LEN = 1518
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_sof,
    input  logic              in_eof,
    input  logic [TAIL_W-1:0] in_tail_bits,
    input  logic              in_crc_good,
    input  logic              acc_crc,
    input  logic              acc_short,
    input  logic              acc_long,
    input  logic [FLAG_W-1:0] irq_en,
    output logic              wr_en,
    output logic              done,
    output logic              keep,
    output logic              irq,
    output logic [FLAG_W-1:0] stat
);
    logic end_beat, start_beat, is_short, is_long;

    rxc_len_tracker #(
        .MIN_LEN (MIN_LEN),
        .MAX_LEN (MAX_LEN)
    ) len_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_sof     (in_sof),
        .in_eof     (in_eof),
        .wr_en      (wr_en),
        .end_beat   (end_beat),
        .start_beat (start_beat),
        .is_short   (is_short),
        .is_long    (is_long)
    );

    rxc_verdict verdict_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .end_beat     (end_beat),
        .start_beat   (start_beat),
        .is_short     (is_short),
        .is_long      (is_long),
        .in_crc_good  (in_crc_good),
        .in_tail_bits (in_tail_bits),
        .acc_crc      (acc_crc),
        .acc_short    (acc_short),
        .acc_long     (acc_long),
        .irq_en       (irq_en),
        .stat         (stat),
        .done         (done),
        .keep         (keep),
        .irq          (irq)
    );

    assert_short_long_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(stat[FL_SHORT] && stat[FL_LONG]));
endmodule

// File: tb/rx_frame_classifier_tb_top.sv
module rx_frame_classifier_tb_top;
    localparam int MIN_LEN = 64;
    localparam int MAX_LEN = 1518;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
    logic [2:0] in_tail_bits = '0;
    logic       in_crc_good = 1'b1;
    logic       acc_crc = 1'b0, acc_short = 1'b0, acc_long = 1'b0;
    logic [4:0] irq_en = '0;
    logic       wr_en, done, keep, irq;
    logic [4:0] stat;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    rx_frame_classifier #(.MIN_LEN(MIN_LEN), .MAX_LEN(MAX_LEN)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof),
        .in_tail_bits(in_tail_bits), .in_crc_good(in_crc_good),
        .acc_crc(acc_crc), .acc_short(acc_short), .acc_long(acc_long), .irq_en(irq_en),
        .wr_en(wr_en), .done(done), .keep(keep), .irq(irq), .stat(stat)
    );

    // Behavioural reference model
    bit         m_open;
    int         m_cnt;
    logic [4:0] e_stat;
    bit         e_done, e_keep, e_irq;

    always @(posedge clk) begin
        int  len;
        bit  f_crc, f_short, f_long, f_drib, f_align;
        if (!rst_n) begin
            m_open = 0; m_cnt = 0; e_stat = '0; e_done = 0; e_keep = 0; e_irq = 0;
        end else begin
            e_done = 0; e_keep = 0; e_irq = 0;
            if (in_valid && (in_sof || m_open)) begin
                len = in_sof ? 1 : m_cnt + 1;
                if (in_sof) e_stat = '0;
                if (in_eof) begin
                    f_crc   = !in_crc_good;
                    f_short = len < MIN_LEN;
                    f_long  = len > MAX_LEN;
                    f_drib  = in_tail_bits != 0;
                    f_align = f_drib && f_crc;
                    e_stat  = {f_align, f_drib, f_long, f_short, f_crc};
                    e_done  = 1;
                    e_keep  = (!f_crc || acc_crc) && (!f_short || acc_short) && (!f_long || acc_long);
                    e_irq   = |(e_stat & irq_en);
                    m_open  = 0; m_cnt = 0;
                end else begin
                    m_open = 1; m_cnt = len;
                end
            end
        end
    end

    task automatic check_bit(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic compare();
        bit e_wr;
        e_wr = in_valid && (in_sof || m_open) && ((in_sof ? 1 : m_cnt + 1) <= MAX_LEN);
        check_bit("R2 wr_en", wr_en, e_wr);
        check_bit("R3 crc flag", stat[0], e_stat[0]);
        check_bit("R4 short flag R11", stat[1], e_stat[1]);
        check_bit("R5 oversize flag", stat[2], e_stat[2]);
        check_bit("R6 dribble flag", stat[3], e_stat[3]);
        check_bit("R7 align flag", stat[4], e_stat[4]);
        check_bit("R9 done", done, e_done);
        check_bit("R8 keep", keep, e_keep);
        check_bit("R10 irq", irq, e_irq);
    endtask

    task automatic drive(input bit v, input bit s, input bit e, input logic [2:0] t, input bit c);
        @(negedge clk);
        in_valid = v; in_sof = s; in_eof = e; in_tail_bits = t; in_crc_good = c;
        #2;
        compare();
    endtask

    // Frame of len bytes; an idle cycle is inserted after byte gap_at (0 = none)
    task automatic send_frame(input int len, input logic [2:0] t, input bit c, input int gap_at);
        for (int i = 1; i <= len; i++) begin
            drive(1, i == 1, i == len, (i == len) ? t : 3'd0, (i == len) ? c : 1'b1);
            if (i == gap_at) drive(0, 0, 0, 0, 1);
        end
        drive(0, 0, 0, 0, 1);
        drive(0, 0, 0, 0, 1);
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        #2;
        // R1: reset state
        check_bit("R1 stat zero", |stat, 1'b0);
        check_bit("R1 done", done, 1'b0);
        check_bit("R1 keep", keep, 1'b0);
        check_bit("R1 irq", irq, 1'b0);
        check_bit("R1 wr_en", wr_en, 1'b0);
        @(negedge clk); rst_n = 1'b1;
        drive(0, 0, 0, 0, 1);

        irq_en = 5'b11111;
        send_frame(64, 0, 1, 0);          // clean minimum length: kept
        send_frame(63, 0, 1, 0);          // R4 short, not accepted
        acc_short = 1;
        send_frame(63, 0, 1, 10);         // R4 short accepted, gap mid-frame
        send_frame(40, 3'd5, 0, 0);       // R7 short + crc + dribble -> align, crc not accepted
        acc_crc = 1;
        send_frame(80, 3'd2, 0, 0);       // R7 align, accepted
        send_frame(70, 3'd7, 1, 0);       // R6 dribble only, kept
        send_frame(MAX_LEN, 0, 1, 0);     // R5 boundary: not oversize
        send_frame(MAX_LEN + 1, 0, 1, 0); // R5 oversize not accepted, R2 truncation
        acc_long = 1;
        send_frame(1600, 0, 0, 700);      // R5 + R3 oversize accepted with crc error
        irq_en = 5'b00100;
        send_frame(100, 0, 0, 0);         // R10 crc error but its irq disabled
        irq_en = 5'b01000;
        send_frame(100, 3'd1, 1, 0);      // R10 dribble irq only
        irq_en = 5'b11111;
        acc_crc = 0; acc_short = 0; acc_long = 0;
        send_frame(1, 0, 1, 0);           // R12 one-byte frame, both markers
        // stray beats outside a frame: R2 no write
        drive(1, 0, 0, 0, 1);
        drive(1, 0, 1, 3'd3, 0);
        drive(0, 0, 0, 0, 1);
        // R12 restart inside a frame, and R11 flag clear on start
        for (int i = 1; i <= 30; i++) drive(1, i == 1, 0, 0, 1);
        for (int i = 1; i <= 64; i++) drive(1, i == 1, i == 64, 0, 1);
        drive(0, 0, 0, 0, 1);
        // R11: flags from a bad frame held, then cleared by next start
        send_frame(20, 3'd4, 0, 0);
        repeat (3) drive(0, 0, 0, 0, 1);
        drive(1, 1, 0, 0, 1);
        drive(0, 0, 0, 0, 1);
        check_bit("R11 flags cleared after start", |stat, 1'b0);
        for (int i = 2; i <= 65; i++) drive(1, 0, i == 65, 0, 1);
        // back-to-back frames with no idle between
        for (int i = 1; i <= 64; i++) drive(1, i == 1, i == 64, 0, 1);
        send_frame(64, 3'd1, 0, 0);
        report();
    end
endmodule